// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block paces one external bus access at a time. The access runs through the states T1 and T2, then zero or more wait states TW, then T3. The block decides how many wait states to insert. It produces only the timing of the access. It drives no address, data or chip-select lines. Other logic watches its state output to drive those lines, its busy flag to hold off new traffic, and its done strobe to complete the transfer.

The wait count has two 2-bit inputs. One serves accesses to the normal area and one serves the extended area. The area-select input picks between them. A 2-bit mode input chooses one of three wait modes:

- **Program mode** inserts the count as given.
- **Pin mode** inserts the count, then keeps adding wait states while the active-low wait input stays low.
- **Auto mode** inserts the count only if the wait input is low during T2, and never inserts more than the count.

The wait input is captured on the falling clock edge. The state machine advances on the rising edge and uses that captured value.

The mode, the area select and both count inputs are latched when a request is accepted. The latched copy resets to program mode with a count of 3, so the wait input plays no part until an access latches a new mode.

Top module: `ext_wait_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, bus_state is 0 (idle), busy is 0 and done is 0.
- R2: When bus_state is idle and req is high at a rising edge, bus_state is 1 (T1) in the next cycle and 2 (T2) in the cycle after. busy is 1 in every state other than idle.
- R3: bus_state follows the order T1, T2, zero or more cycles of 3 (TW), 4 (T3), then idle. Wait states appear only between T2 and T3.
- R4: In program mode (wmode 00, and also 11), exactly the latched count of TW cycles is inserted, whatever wait_n does.
- R5: In pin mode (wmode 01), the latched count of TW cycles is inserted first. After that, one more TW is added each time wait_n is low at the falling edge inside the last T2 or TW cycle. With a count of 0, the falling edge inside T2 is the first sample. If wait_n is low for L consecutive sampled cycles starting at T2 and high afterwards, the number of TW cycles is max(count, L).
- R6: In auto mode (wmode 10), wait_n is sampled only at the falling edge inside T2. If it is low there, exactly the latched count of TW cycles is inserted. If it is high, none is inserted. Holding wait_n low longer never adds wait states.
- R7: The count comes from wcnt_ext when ext_area is 1 at acceptance, and from wcnt_norm when ext_area is 0.
- R8: done is 1 only in the single T3 cycle. The cycle after T3 is always idle, even if req stays high. A held request starts its next T1 only after that idle cycle.
- R9: Changes to wmode, ext_area, wcnt_norm or wcnt_ext after a request is accepted have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state machine uses the rising edge, the wait capture uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted only when idle |
| ext_area | input | 1 | 1 selects the extended-area wait count |
| wcnt_norm | input | 2 | Wait count for the normal area |
| wcnt_ext | input | 2 | Wait count for the extended area |
| wmode | input | 2 | Wait mode: 00 program, 01 pin, 10 auto, 11 program |
| wait_n | input | 1 | External wait request, active low |
| bus_state | output | 3 | 0 idle, 1 T1, 2 T2, 3 TW, 4 T3 |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle strobe in T3 |

## Verification
A bad remaining-wait count or a misread wait sample shows up as a TW run of the wrong length. T3 and done then arrive one or more cycles early or late within the same access, so the bench counts TW cycles against a closed-form expected value for each mode. A configuration register that is not held shows up when the inputs change right after T1. A wrong transition out of T3 shows up in the next cycle as a missing idle state while the request is held high.

// File: rtl/ext_wait_seq.sv
module ext_wait_seq #(
  parameter int CW = 2,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          ext_area,
  input  logic [CW-1:0] wcnt_norm,
  input  logic [CW-1:0] wcnt_ext,
  input  logic [1:0]    wmode,
  input  logic          wait_n,
  output logic [SW-1:0] bus_state,
  output logic          busy,
  output logic          done
);

  localparam logic [SW-1:0] S_IDLE = SW'(0);
  localparam logic [SW-1:0] S_T1   = SW'(1);
  localparam logic [SW-1:0] S_T2   = SW'(2);
  localparam logic [SW-1:0] S_TW   = SW'(3);
  localparam logic [SW-1:0] S_T3   = SW'(4);
  localparam logic [1:0]    M_PIN  = 2'b01;
  localparam logic [1:0]    M_AUTO = 2'b10;
  localparam logic [CW-1:0] CNT_RST = {CW{1'b1}};

  logic [SW-1:0] st, st_nx;
  logic [CW-1:0] rem, rem_nx;
  logic [CW-1:0] cnt_q;
  logic [1:0]    mode_q;
  logic          wait_q;

  wire pin_m  = (mode_q == M_PIN);
  wire auto_m = (mode_q == M_AUTO);
  wire low_q  = ~wait_q;
  wire accept = (st == S_IDLE) && req;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) wait_q <= 1'b1;
    else        wait_q <= wait_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      mode_q <= 2'b00;
    end else if (accept) begin
      cnt_q  <= ext_area ? wcnt_ext : wcnt_norm;
      mode_q <= wmode;
    end

  always_comb begin
    st_nx  = st;
    rem_nx = rem;
    case (st)
      S_IDLE: if (req) st_nx = S_T1;
      S_T1:   st_nx = S_T2;
      S_T2: begin
        if (auto_m) begin
          if (low_q && cnt_q != '0) begin st_nx = S_TW; rem_nx = cnt_q; end
          else st_nx = S_T3;
        end else if (cnt_q != '0) begin
          st_nx = S_TW; rem_nx = cnt_q;
        end else if (pin_m && low_q) begin
          st_nx = S_TW; rem_nx = '0;
        end else st_nx = S_T3;
      end
      S_TW: begin
        if (rem > CW'(1)) rem_nx = rem - CW'(1);
        else if (pin_m && low_q) rem_nx = '0;
        else st_nx = S_T3;
      end
      S_T3:    st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      rem <= '0;
    end else begin
      st  <= st_nx;
      rem <= rem_nx;
    end

  assign bus_state = st;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_T3);

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T1) |=> (st == S_T2)); // R2
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st == S_T1)); // R2
  AST_TW_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW) |-> ($past(st) == S_T2 || $past(st) == S_TW)); // R3
  AST_T3_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3) |=> (st == S_IDLE)); // R8
  AST_CAPPED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW && !pin_m) |-> (rem != '0)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cnt_q) && $stable(mode_q))); // R9

endmodule

// File: tb/tb_ext_wait_seq.sv
module tb_ext_wait_seq;
  logic clk = 0, rst_n = 0, req = 0, ext_area = 0, wait_n = 1;
  logic [1:0] wcnt_norm = 0, wcnt_ext = 0, wmode = 0;
  logic [2:0] bus_state;
  logic busy, done;
  int n_chk = 0, n_bad = 0;

  localparam logic [2:0] ST_IDLE = 0, ST_T1 = 1, ST_T2 = 2, ST_TW = 3, ST_T3 = 4;

  always #5 clk = ~clk;

  ext_wait_seq dut (.clk(clk), .rst_n(rst_n), .req(req), .ext_area(ext_area),
    .wcnt_norm(wcnt_norm), .wcnt_ext(wcnt_ext), .wmode(wmode), .wait_n(wait_n),
    .bus_state(bus_state), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_tw(input logic [1:0] m, input int c, input int l);
    if (m == 2'b01) return (l > c) ? l : c;
    if (m == 2'b10) return (l >= 1 && c > 0) ? c : 0;
    return c;
  endfunction

  task automatic run_access(input logic [1:0] m, input bit ar, input int cn,
                            input int ce, input int l, input bit chg, input bit hold);
    int c, tw, idx, exp;
    wmode = m; ext_area = ar; wcnt_norm = 2'(cn); wcnt_ext = 2'(ce);
    wait_n = $urandom % 2; req = 1;
    c = ar ? ce : cn;
    exp = exp_tw(m, c, l);
    @(posedge clk); #1;
    chk(bus_state == ST_T1 && busy && !done, "R2 T1", bus_state, ST_T1);
    if (!hold) req = 0;
    if (chg) begin
      wmode = $urandom % 4; ext_area = $urandom % 2;
      wcnt_norm = $urandom % 4; wcnt_ext = $urandom % 4;
    end
    @(posedge clk); #1;
    chk(bus_state == ST_T2 && busy, "R2 T2", bus_state, ST_T2);
    wait_n = (0 < l) ? 1'b0 : 1'b1;
    tw = 0; idx = 1;
    @(posedge clk); #1;
    while (bus_state == ST_TW && tw < 20) begin
      chk(busy && !done, "R3 TW busy", done, 0);
      tw++;
      wait_n = (idx < l) ? 1'b0 : 1'b1;
      idx++;
      @(posedge clk); #1;
    end
    chk(tw == exp, (m == 2'b01) ? "R5 pin waits" : (m == 2'b10) ? "R6 auto waits" :
        ar ? "R7 R4 ext-area waits" : (chg ? "R9 R4 waits" : "R4 program waits"), tw, exp);
    chk(bus_state == ST_T3 && done, "R3 R8 T3 done", bus_state, ST_T3);
    wait_n = $urandom % 2;
    @(posedge clk); #1;
    chk(bus_state == ST_IDLE && !done && !busy, "R8 idle after T3", bus_state, ST_IDLE);
    req = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(20240601);
    #23;
    chk(bus_state == ST_IDLE && !busy && !done, "R1 in reset", bus_state, ST_IDLE);
    @(posedge clk); #1; rst_n = 1;
    @(posedge clk); #1;
    chk(bus_state == ST_IDLE && !busy && !done, "R1 after reset", bus_state, ST_IDLE);
    run_access(2'b00, 0, 0, 3, 9, 0, 0);
    run_access(2'b00, 0, 3, 0, 9, 0, 1);
    run_access(2'b11, 0, 2, 0, 0, 0, 0);
    run_access(2'b01, 0, 0, 0, 0, 0, 0);
    run_access(2'b01, 0, 0, 0, 4, 0, 1);
    run_access(2'b01, 0, 3, 0, 5, 0, 0);
    run_access(2'b01, 0, 2, 0, 1, 0, 0);
    run_access(2'b10, 0, 3, 0, 1, 0, 0);
    run_access(2'b10, 0, 2, 0, 0, 0, 0);
    run_access(2'b10, 0, 1, 0, 6, 0, 0);
    run_access(2'b10, 0, 0, 3, 3, 0, 0);
    run_access(2'b00, 1, 0, 3, 0, 0, 0);
    run_access(2'b00, 1, 3, 1, 0, 1, 0);
    for (int i = 0; i < 300; i++)
      run_access(2'($urandom % 4), 1'($urandom % 2), $urandom % 4, $urandom % 4,
                 $urandom % 7, 1'($urandom % 2), 1'($urandom % 2));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule